// File: doc/BRIEF.md
# Windowed Register Bank with Key Lock

This block is the register front-end of a timer-style peripheral. Each register can be reached through four address windows that differ only in how a write is applied: the plain window replaces the value, while the set, clear and toggle windows use the written data as a bit mask. Software can therefore change single bits without a read-modify-write sequence. Reads return the plain register value whatever window the address falls in.

A 16-bit key protects the configuration, control and compare registers. Writing the unlock key opens them, and writing any other value to the key word closes them again. The enable register reports a short busy period after it is switched off. The software-reset command returns every register except the lock state to its reset value and reports its own busy period. The register contents go straight to the peripheral core as output ports.

Top module: `rb_alias_bank`

## Requirements
- R1: After reset every output is 0, the bank is unlocked, and the version word reads 1.
- R2: The byte address carries the window in bits [13:12] (0 plain, 1 set, 2 clear, 3 toggle) and the word index in bits [11:2]. The word map is 0 version, 1 enable, 2 soft reset, 3 config, 4 status, 5 key, 6 control, and 7 upward one compare word each.
- R3: A plain-window write replaces the writable bits of the register. A read presents the plain value on `rdata_o` on the clock edge that samples `rd_en`, for an address in any window.
- R4: In the set, clear and toggle windows, each 1 bit of the write data sets, clears or inverts the matching register bit, and each 0 bit leaves it unchanged.
- R5: Any write to the key word locks the bank, unless bits [15:0] of the data equal 0x4776, which unlocks it. Status bit 1 reads the lock state (1 = locked) and status bit 0 reads the enable bit.
- R6: While the bank is locked, writes to the config, control and compare words have no effect in any window. The enable word stays writable.
- R7: The version word, the status word, bit 1 of the enable word and bit 1 of the soft-reset word ignore writes. The key word reads 0.
- R8: A write that turns the enable bit from 1 to 0 raises `disabling_o` (enable word bit 1) for DIS_CYC cycles (default 2), starting the cycle after the write.
- R9: A write whose windowed result has soft-reset bit 0 at 1 clears enable, config, control and compare and keeps the lock state. `resetting_o` (soft-reset word bit 1) is then high for RST_CYC cycles (default 2). All writes are ignored during that time, and soft-reset bit 0 always reads 0.
- R10: Word indices above the last compare word read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 14 | Byte address: window and word index |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| en_o | output | 1 | Enable bit |
| cfg_o | output | CFG_W | Config register |
| ctrl_o | output | CTRL_W | Control register |
| cmp_o | output | NUM_CMP*CMP_W | Compare registers, compare 0 in the low slice |
| locked_o | output | 1 | Lock state |
| disabling_o | output | 1 | Disable busy |
| resetting_o | output | 1 | Soft-reset busy |

## Verification
The bench applies all four windows to the same control register in sequence. A design that mixed up the clear and toggle merges would leave bit patterns that differ from the expected values. It locks the bank and then writes through every window to the guarded words, and it checks that the enable word still responds while locked. A lock gate placed on the wrong word would fail one of those two checks. It fires the soft reset through the toggle window while the bank is locked and writes to enable during the busy period. A design that lost the lock state, ran a busy period of the wrong length or accepted that write would show it on the ports. Key values with non-zero upper bits, writes to read-only bits and accesses to unmapped words close the run.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int BUS_W   = 32;
  localparam int WORD_W  = 10;
  localparam int ADDR_W  = WORD_W + 4;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'd0,
    WIN_SET   = 2'd1,
    WIN_CLR   = 2'd2,
    WIN_TGL   = 2'd3
  } win_e;

  localparam int W_VERSION = 0;
  localparam int W_ENABLE  = 1;
  localparam int W_SOFTRST = 2;
  localparam int W_CONFIG  = 3;
  localparam int W_STATUS  = 4;
  localparam int W_KEY     = 5;
  localparam int W_CONTROL = 6;
  localparam int W_CMP0    = 7;

  localparam logic [15:0] OPEN_KEY = 16'h4776;

  // windowed write: result of applying data to the current value
  function automatic logic [BUS_W-1:0] win_merge(win_e w, logic [BUS_W-1:0] cur,
                                                 logic [BUS_W-1:0] d);
    case (w)
      WIN_SET: return cur | d;
      WIN_CLR: return cur & ~d;
      WIN_TGL: return cur ^ d;
      default: return d;
    endcase
  endfunction

  function automatic logic key_opens(logic [BUS_W-1:0] d);
    return d[15:0] == OPEN_KEY;
  endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
#(
  parameter int NUM_WORDS = 9
) (
  input  logic [ADDR_W-1:0]  addr,
  output win_e               win,
  output logic [NUM_WORDS-1:0] sel
);
  logic [WORD_W-1:0] word;
  logic [1:0]        low_unused;

  assign win        = win_e'(addr[ADDR_W-1 -: 2]);
  assign word       = addr[WORD_W+1:2];
  assign low_unused = addr[1:0];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign sel[i] = (word == WORD_W'(i));
  end
endmodule

// File: rtl/rb_busy_timer.sv
module rb_busy_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (start)       cnt <= CW'(CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rb_alias_bank.sv
module rb_alias_bank
  import rb_pkg::*;
#(
  parameter int CFG_W   = 1,
  parameter int CTRL_W  = 11,
  parameter int CMP_W   = 32,
  parameter int NUM_CMP = 2,
  parameter int DIS_CYC = 2,
  parameter int RST_CYC = 2,
  parameter logic [BUS_W-1:0] VERSION = 32'd1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BUS_W-1:0]         wdata,
  output logic [BUS_W-1:0]         rdata_o,
  output logic                     en_o,
  output logic [CFG_W-1:0]         cfg_o,
  output logic [CTRL_W-1:0]        ctrl_o,
  output logic [NUM_CMP*CMP_W-1:0] cmp_o,
  output logic                     locked_o,
  output logic                     disabling_o,
  output logic                     resetting_o
);
  localparam int NUM_WORDS = W_CMP0 + NUM_CMP;

  win_e                 win;
  logic [NUM_WORDS-1:0] sel;

  rb_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
    .addr (addr),
    .win  (win),
    .sel  (sel)
  );

  // state
  logic             en_q;
  logic             locked_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CMP_W-1:0] cmp_q [NUM_CMP];

  // named write events
  logic wr_ok;
  logic key_hit, en_hit, cfg_hit, ctrl_hit, softrst_fire, dis_start, en_next;
  logic [NUM_CMP-1:0] cmp_hit;
  logic [BUS_W-1:0]   srst_merged, en_merged;

  assign wr_ok     = we && !resetting_o;
  assign key_hit   = wr_ok && sel[W_KEY];
  assign en_hit    = wr_ok && sel[W_ENABLE];
  assign cfg_hit   = wr_ok && sel[W_CONFIG]  && !locked_q;
  assign ctrl_hit  = wr_ok && sel[W_CONTROL] && !locked_q;

  // soft-reset bit reads 0, so merge against zero
  assign srst_merged  = win_merge(win, '0, wdata);
  assign softrst_fire = wr_ok && sel[W_SOFTRST] && srst_merged[0];

  assign en_merged = win_merge(win, BUS_W'(en_q), wdata);
  assign en_next   = en_merged[0];
  assign dis_start = en_hit && en_q && !en_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             locked_q <= 1'b0;
    else if (key_hit)       locked_q <= !key_opens(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else if (softrst_fire) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (en_hit)   en_q   <= en_next;
      if (cfg_hit)  cfg_q  <= CFG_W'(win_merge(win, BUS_W'(cfg_q), wdata));
      if (ctrl_hit) ctrl_q <= CTRL_W'(win_merge(win, BUS_W'(ctrl_q), wdata));
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmp_hit[i] = wr_ok && sel[W_CMP0+i] && !locked_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cmp_q[i] <= '0;
      else if (softrst_fire) cmp_q[i] <= '0;
      else if (cmp_hit[i])   cmp_q[i] <= CMP_W'(win_merge(win, BUS_W'(cmp_q[i]), wdata));
    end
    assign cmp_o[i*CMP_W +: CMP_W] = cmp_q[i];
  end

  rb_busy_timer #(.CYC(DIS_CYC)) u_dis (
    .clk (clk), .rst_n (rst_n), .start (dis_start), .clear (softrst_fire),
    .busy (disabling_o)
  );

  rb_busy_timer #(.CYC(RST_CYC)) u_rst (
    .clk (clk), .rst_n (rst_n), .start (softrst_fire), .clear (1'b0),
    .busy (resetting_o)
  );

  // read path: per-word values, one-hot OR
  logic [BUS_W-1:0] wv [NUM_WORDS];
  logic [BUS_W-1:0] rd_val;

  assign wv[W_VERSION] = VERSION;
  assign wv[W_ENABLE]  = BUS_W'({disabling_o, en_q});
  assign wv[W_SOFTRST] = BUS_W'({resetting_o, 1'b0});
  assign wv[W_CONFIG]  = BUS_W'(cfg_q);
  assign wv[W_STATUS]  = BUS_W'({locked_q, en_q});
  assign wv[W_KEY]     = '0;
  assign wv[W_CONTROL] = BUS_W'(ctrl_q);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_rdcmp
    assign wv[W_CMP0+i] = BUS_W'(cmp_q[i]);
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (sel[i]) rd_val = rd_val | wv[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_val;
  end

  assign en_o     = en_q;
  assign cfg_o    = cfg_q;
  assign ctrl_o   = ctrl_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/rb_alias_bank_chk.sv
module rb_alias_bank_chk #(
  parameter int CTRL_W  = 11,
  parameter int CFG_W   = 1,
  parameter int NUM_CMP = 2,
  parameter int CMP_W   = 32,
  parameter int RST_CYC = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     we,
  input logic [31:0]              wdata,
  input logic                     ctrl_sel,
  input logic                     key_hit,
  input logic                     softrst_fire,
  input logic                     en_o,
  input logic [CFG_W-1:0]         cfg_o,
  input logic [CTRL_W-1:0]        ctrl_o,
  input logic [NUM_CMP*CMP_W-1:0] cmp_o,
  input logic                     locked_o,
  input logic                     disabling_o,
  input logic                     resetting_o
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy_run <= '0;
    else if (!resetting_o)              busy_run <= '0;
    else if (busy_run != 8'hFF)         busy_run <= busy_run + 1'b1;
  end

  // R6
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ctrl_sel && locked_o) |=> $stable(ctrl_o));

  // R9
  softrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softrst_fire |=> (!en_o && cfg_o == '0 && ctrl_o == '0 && cmp_o == '0 && resetting_o));

  // R9
  softrst_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softrst_fire |=> (locked_o == $past(locked_o)));

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 8'(RST_CYC));

  // R9
  busy_ignores_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resetting_o && we) |=> ($stable(en_o) && $stable(ctrl_o) && $stable(locked_o)));

  // R8
  disabling_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disabling_o) |-> $fell(en_o));

  // R5
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && wdata[15:0] == 16'h4776) |=> !locked_o);
endmodule

bind rb_alias_bank rb_alias_bank_chk #(
  .CTRL_W (CTRL_W), .CFG_W (CFG_W), .NUM_CMP (NUM_CMP), .CMP_W (CMP_W), .RST_CYC (RST_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .we           (we),
  .wdata        (wdata),
  .ctrl_sel     (sel[rb_pkg::W_CONTROL]),
  .key_hit      (key_hit),
  .softrst_fire (softrst_fire),
  .en_o         (en_o),
  .cfg_o        (cfg_o),
  .ctrl_o       (ctrl_o),
  .cmp_o        (cmp_o),
  .locked_o     (locked_o),
  .disabling_o  (disabling_o),
  .resetting_o  (resetting_o)
);

// File: tb/tb_rb_alias_bank.sv
module tb_rb_alias_bank;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        rd_en = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        en_o, locked_o, disabling_o, resetting_o;
  logic [0:0]  cfg_o;
  logic [10:0] ctrl_o;
  logic [63:0] cmp_o;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  rb_alias_bank dut (
    .clk (clk), .rst_n (rst_n), .we (we), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata_o (rdata_o), .en_o (en_o), .cfg_o (cfg_o),
    .ctrl_o (ctrl_o), .cmp_o (cmp_o), .locked_o (locked_o),
    .disabling_o (disabling_o), .resetting_o (resetting_o)
  );

  function automatic logic [13:0] mk(int w, int word);
    return {w[1:0], word[9:0], 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int w, int word, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = mk(w, word); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int w, int word, logic [31:0] exp, string tag);
    exp_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = mk(w, word); sb.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // monitor: compares read data against the scoreboard
  always @(posedge clk) begin
    if (rd_en) begin
      exp_t it;
      #1;
      if (sb.size() == 0) begin
        checks++; errs++;
        $display("FAIL R3 unexpected read actual=%h expected=none", rdata_o);
      end else begin
        it = sb.pop_front();
        chk(it.tag, rdata_o, it.exp);
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 outputs", {en_o, locked_o, disabling_o, resetting_o, cfg_o, ctrl_o}, '0);
    chk("R1 cmp", cmp_o[31:0] | cmp_o[63:32], '0);
    rd(0, 0, 32'd1, "R1 version");
    rd(2, 4, 32'd0, "R1 status");
    // R2 R3 plain write, reads from other windows
    wr(0, 6, 32'h0000_0155);
    chk("R3 ctrl plain", 32'(ctrl_o), 32'h155);
    rd(3, 6, 32'h155, "R2 read via toggle window");
    // R4 windows
    wr(1, 6, 32'h0000_0600);
    chk("R4 set", 32'(ctrl_o), 32'h755);
    wr(2, 6, 32'h0000_0005);
    chk("R4 clear", 32'(ctrl_o), 32'h750);
    wr(3, 6, 32'h0000_00FF);
    chk("R4 toggle", 32'(ctrl_o), 32'h7AF);
    wr(0, 8, 32'hDEAD_BEEF);
    rd(1, 8, 32'hDEAD_BEEF, "R3 cmp1 readback");
    wr(1, 7, 32'h0000_00F0);
    chk("R4 cmp0 set", cmp_o[31:0], 32'h0000_00F0);
    // R5 lock
    wr(0, 5, 32'h0000_1234);
    chk("R5 locked", 32'(locked_o), 1);
    rd(0, 4, 32'd2, "R5 status locked");
    // R6 guarded writes ignored in every window
    wr(0, 6, 32'h0);
    wr(2, 6, 32'hFFFF_FFFF);
    chk("R6 ctrl locked", 32'(ctrl_o), 32'h7AF);
    wr(1, 7, 32'h0000_000F);
    wr(3, 8, 32'hFFFF_FFFF);
    chk("R6 cmp0 locked", cmp_o[31:0], 32'h0000_00F0);
    chk("R6 cmp1 locked", cmp_o[63:32], 32'hDEAD_BEEF);
    wr(1, 3, 32'h1);
    chk("R6 cfg locked", 32'(cfg_o), 0);
    wr(1, 1, 32'h1);
    chk("R6 enable still writable", 32'(en_o), 1);
    rd(0, 4, 32'd3, "R5 status locked+enabled");
    // R5 unlock with upper bits set
    wr(0, 5, 32'hFFFF_4776);
    chk("R5 unlocked", 32'(locked_o), 0);
    wr(1, 3, 32'h1);
    chk("R6 cfg after unlock", 32'(cfg_o), 1);
    // R7 read-only
    wr(0, 0, 32'h0);
    rd(0, 0, 32'd1, "R7 version");
    wr(0, 4, 32'hFFFF_FFFF);
    rd(0, 4, 32'd1, "R7 status");
    wr(0, 1, 32'h3);
    rd(0, 1, 32'd1, "R7 enable bit1");
    rd(0, 5, 32'd0, "R7 key reads 0");
    // R8 disabling busy
    wr(2, 1, 32'h1);
    chk("R8 enable off", 32'(en_o), 0);
    chk("R8 busy c1", 32'(disabling_o), 1);
    @(negedge clk);
    chk("R8 busy c2", 32'(disabling_o), 1);
    @(negedge clk);
    chk("R8 busy end", 32'(disabling_o), 0);
    // R9 soft reset via clear window does nothing
    wr(2, 2, 32'h1);
    chk("R9 clear window no reset", 32'(resetting_o), 0);
    chk("R9 cfg kept", 32'(cfg_o), 1);
    // R9 soft reset while locked
    wr(0, 1, 32'h1);
    wr(0, 5, 32'h0);
    wr(3, 2, 32'h1);
    chk("R9 regs cleared", {31'b0, en_o} | 32'(cfg_o) | 32'(ctrl_o) | cmp_o[31:0] | cmp_o[63:32], 0);
    chk("R9 lock kept", 32'(locked_o), 1);
    chk("R9 busy c1", 32'(resetting_o), 1);
    @(negedge clk); we = 1'b1; addr = mk(0, 1); wdata = 32'h1;
    @(negedge clk); we = 1'b0;
    chk("R9 write during busy ignored", 32'(en_o), 0);
    chk("R9 busy end", 32'(resetting_o), 0);
    rd(0, 2, 32'd0, "R9 softrst reads 0");
    // R10 unmapped
    wr(0, 9, 32'hFFFF_FFFF);
    rd(0, 9, 32'd0, "R10 word 9");
    wr(1, 300, 32'hFFFF_FFFF);
    rd(2, 300, 32'd0, "R10 word 300");
    chk("R10 no side effect", 32'(en_o) | 32'(ctrl_o), 0);
    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errs++;
      $display("FAIL R3 pending reads actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule